// File: doc/BRIEF.md
# Sideband Mailbox Transaction Sequencer

This block turns one host-side sideband request into the full register sequence a sideband mailbox expects. A mailbox sits behind a configuration-register master port. The caller hands over a destination port ID, a 32-bit register offset, an opcode, a posted flag, byte enables, a BAR index, a function ID and write data. The sequencer first checks that it can run the request. It checks that the opcode is one the mailbox knows and that the mailbox device answers on its identity register. It then waits for the mailbox to go idle and writes the message registers in the one order the mailbox accepts. After that it fires the message and waits for it to finish.

When the message ends, the result comes back with a one-cycle done pulse. The result carries a pass flag and a failure class, which is one of: bad opcode, hidden device, timeout, or negative response. It also carries the mailbox response code and, for read-type opcodes, the returned data. Each wait for the busy bit is bounded by a parameterised number of status reads.

Top module: `sbx_seq`

## Requirements
- R1: `cmd_ready` is high only while the sequencer is idle. A command is taken on a cycle with `cmd_valid` and `cmd_ready` both high. Each command yields exactly one single-cycle `res_done`, and `res_ok` is high exactly when `res_err` is 0.
- R2: An opcode outside {0,1,4,5,6,7,13} ends the command with `res_err`=1. This happens on the cycle after acceptance, and no configuration access is made.
- R3: The first access is a 16-bit read at byte address 0x00. If it returns 0xFFFF, the command ends with `res_err`=2 and no further access is made.
- R4: Before programming, the 16-bit status register at 0xD8 is read until bit 0 (busy) is 0. At most POLL_LIMIT reads are made. If all of them see busy, the command ends with `res_err`=3 and no write is made.
- R5: The first two writes are 32-bit. The first goes to 0xD0 with {port ID in bits 31:24, zero in bits 23:16, offset[15:0]}. The second goes to 0xDC with offset[31:16] in bits 15:0.
- R6: Next the status register is read once. It is then written back (16-bit, 0xD8) with bits 15:8 set to the opcode, bit 7 set to the posted flag, and bits 6:0 kept as read.
- R7: Next a 16-bit write to 0xDA carries {byte enables in 15:12, 0 in bit 11, BAR in 10:8, function ID in 7:0}.
- R8: Next a 32-bit write to 0xD4 carries the caller's data for opcodes 1, 5 and 7, and zero for every other opcode.
- R9: The status register is then read and written back with bit 0 set. It is then polled until busy clears, with the same bound as R4. A timeout here ends with `res_err`=3.
- R10: `res_rsp` is set to 0xFF when a command is taken. It changes only when the final poll sees busy clear, and then takes status bits 2:1. A nonzero code ends with `res_err`=4.
- R11: On success for opcodes 0, 4 and 6, a 32-bit read of 0xD4 is made and its value appears on `res_rdata`. For all other outcomes `res_rdata` is 0.
- R12: `cfg_req` stays high with address, direction, width and write data unchanged until the cycle `cfg_ack` is seen. 16-bit accesses use data bits 15:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command can be taken |
| cmd_pid | input | 8 | Destination port ID |
| cmd_ofs | input | 32 | Register offset within the port |
| cmd_op | input | 8 | Message opcode |
| cmd_posted | input | 1 | Posted-message flag |
| cmd_fbe | input | 4 | Byte enables |
| cmd_bar | input | 3 | BAR index |
| cmd_fid | input | 8 | Function ID |
| cmd_wdata | input | 32 | Data for write-type opcodes |
| res_done | output | 1 | One-cycle result pulse |
| res_ok | output | 1 | Command completed successfully |
| res_err | output | 3 | 0 none, 1 bad opcode, 2 hidden, 3 timeout, 4 negative response |
| res_rsp | output | 8 | Response code, 0xFF when not reached |
| res_rdata | output | 32 | Read data for read-type opcodes |
| cfg_req | output | 1 | Configuration access request |
| cfg_we | output | 1 | 1 write, 0 read |
| cfg_wide | output | 1 | 1 for 32-bit, 0 for 16-bit access |
| cfg_addr | output | 8 | Configuration byte address |
| cfg_wdata | output | 32 | Write data |
| cfg_ack | input | 1 | Access complete, read data valid |
| cfg_rdata | input | 32 | Read data |

## Verification
The bench targets the poll bound on both sides of the trigger. When the mailbox stays busy for exactly one read fewer than the limit, the command must succeed. When it stays busy through the limit, the command must fail. A counter off by one would cost a spurious timeout or one read too many. Other stimuli leave junk in the status register's upper bits, pass write data with a non-write opcode, and set offsets above 16 bits. These catch a read-modify-write that leaks old opcode bits, a lost posted flag, dummy data replaced by live data, or a dropped extended address. Failure stimuli cover an illegal opcode, a hidden device and a negative response. Each must stop traffic at once and leave the response at 0xFF, or at the returned code when the mailbox answered.

// File: rtl/sbx_pkg.sv
`timescale 1ns/1ps
// sbx_pkg: shared types, mailbox register map and opcode classes.
// Assumes a byte-addressed configuration space of 256 bytes.
package sbx_pkg;

    localparam int PID_W = 8;
    localparam int OFS_W = 32;
    localparam int DAT_W = 32;
    localparam int OP_W  = 8;
    localparam int CAD_W = 8;
    localparam int STS_W = 16;

    // Register byte addresses decoded by the mailbox itself.
    localparam logic [CAD_W-1:0] RA_IDENT = 8'h00;
    localparam logic [CAD_W-1:0] RA_ADDR  = 8'hD0;
    localparam logic [CAD_W-1:0] RA_DATA  = 8'hD4;
    localparam logic [CAD_W-1:0] RA_STAT  = 8'hD8;
    localparam logic [CAD_W-1:0] RA_ROUTE = 8'hDA;
    localparam logic [CAD_W-1:0] RA_EXTA  = 8'hDC;

    localparam logic [STS_W-1:0] STS_KEEP = 16'h007F;
    localparam logic [15:0]      ID_ABSENT = 16'hFFFF;

    typedef enum logic [2:0] {
        SBX_OK      = 3'd0,
        SBX_BAD_OP  = 3'd1,
        SBX_HIDDEN  = 3'd2,
        SBX_TIMEOUT = 3'd3,
        SBX_NACK    = 3'd4
    } sbx_err_e;

    typedef enum logic [3:0] {
        S_IDLE, S_IDENT, S_POLA, S_WADR, S_WEXT, S_RST, S_WST,
        S_WRTE, S_WDAT, S_RST2, S_WGO, S_POLB, S_RDAT
    } sbx_state_e;

    function automatic logic sbx_op_legal(input logic [OP_W-1:0] op);
        return (op == 8'd0) || (op == 8'd1) || (op == 8'd4) || (op == 8'd5) ||
               (op == 8'd6) || (op == 8'd7) || (op == 8'd13);
    endfunction

    function automatic logic sbx_op_writes(input logic [OP_W-1:0] op);
        return (op == 8'd1) || (op == 8'd5) || (op == 8'd7);
    endfunction

    function automatic logic sbx_op_reads(input logic [OP_W-1:0] op);
        return (op == 8'd0) || (op == 8'd4) || (op == 8'd6);
    endfunction

endpackage

// File: rtl/sbx_field_pack.sv
`timescale 1ns/1ps
// sbx_field_pack: builds every word the sequencer writes into the mailbox
// from the latched command and the last status value read.
// Purely combinational; assumes inputs are stable while an access is open.
module sbx_field_pack
    import sbx_pkg::*;
(
    input  logic [PID_W-1:0] pid,
    input  logic [OFS_W-1:0] ofs,
    input  logic [OP_W-1:0]  op,
    input  logic             posted,
    input  logic [3:0]       fbe,
    input  logic [2:0]       bar,
    input  logic [7:0]       fid,
    input  logic [DAT_W-1:0] wdata,
    input  logic [STS_W-1:0] sts_seen,
    output logic [DAT_W-1:0] adr_word,
    output logic [DAT_W-1:0] ext_word,
    output logic [STS_W-1:0] sts_cfg,
    output logic [STS_W-1:0] rte_word,
    output logic [DAT_W-1:0] dat_word,
    output logic [STS_W-1:0] sts_go
);
    localparam int HI_W = OFS_W - 16;

    // Pack address, extended address, status, routing and data words.
    always_comb begin
        adr_word = {pid, 8'h00, ofs[15:0]};
        ext_word = {{(DAT_W-HI_W){1'b0}}, ofs[OFS_W-1:16]};
        sts_cfg  = (sts_seen & STS_KEEP) | {op, 8'h00} | {8'h00, posted, 7'h00};
        rte_word = {fbe, 1'b0, bar, fid};
        dat_word = sbx_op_writes(op) ? wdata : '0;
        sts_go   = sts_seen | 16'h0001;
    end

endmodule

// File: rtl/sbx_poll_timer.sv
`timescale 1ns/1ps
// sbx_poll_timer: counts the status reads left in one polling phase.
// Reloaded at the start of each phase; 'last' flags the final allowed read.
// Assumes the caller never decrements while 'last' is high.
module sbx_poll_timer #(
    parameter int LIMIT = 16,
    localparam int CNT_W = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic dec,
    output logic last
);
    logic [CNT_W-1:0] cnt_q;

    // Reload on a new phase, count down on each busy read.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= CNT_W'(LIMIT);
        else if (load)   cnt_q <= CNT_W'(LIMIT);
        else if (dec)    cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == CNT_W'(1));

    a_r4_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) && (cnt_q <= CNT_W'(LIMIT)));
    a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> !last);

endmodule

// File: rtl/sbx_cfg_port.sv
`timescale 1ns/1ps
// sbx_cfg_port: single-outstanding configuration master.
// A 'go' pulse opens an access that is held until cfg_ack; 'fin' marks the
// ack cycle and 'fin_data' carries the read data in that cycle.
module sbx_cfg_port
    import sbx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [CAD_W-1:0] go_addr,
    input  logic             go_we,
    input  logic             go_wide,
    input  logic [DAT_W-1:0] go_wdata,
    output logic             fin,
    output logic [DAT_W-1:0] fin_data,
    output logic             cfg_req,
    output logic             cfg_we,
    output logic             cfg_wide,
    output logic [CAD_W-1:0] cfg_addr,
    output logic [DAT_W-1:0] cfg_wdata,
    input  logic             cfg_ack,
    input  logic [DAT_W-1:0] cfg_rdata
);
    // Open an access on go, close it on ack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_req   <= 1'b0;
            cfg_we    <= 1'b0;
            cfg_wide  <= 1'b0;
            cfg_addr  <= '0;
            cfg_wdata <= '0;
        end else if (go) begin
            cfg_req   <= 1'b1;
            cfg_we    <= go_we;
            cfg_wide  <= go_wide;
            cfg_addr  <= go_addr;
            cfg_wdata <= go_wdata;
        end else if (cfg_ack) begin
            cfg_req   <= 1'b0;
        end
    end

    assign fin      = cfg_req & cfg_ack;
    assign fin_data = cfg_rdata;

    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && !cfg_ack) |=> (cfg_req && $stable(cfg_addr) && $stable(cfg_we)
                                   && $stable(cfg_wide) && $stable(cfg_wdata)));
    a_r12_one_open: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !cfg_req);

endmodule

// File: rtl/sbx_seq.sv
`timescale 1ns/1ps
// sbx_seq: runs one sideband message through the mailbox registers:
// opcode check, identity check, idle poll, fixed-order programming,
// trigger, completion poll, response check and optional data read-back.
// Assumes one mailbox behind the configuration port and one command at a time.
module sbx_seq
    import sbx_pkg::*;
#(
    parameter int POLL_LIMIT = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [PID_W-1:0] cmd_pid,
    input  logic [OFS_W-1:0] cmd_ofs,
    input  logic [OP_W-1:0]  cmd_op,
    input  logic             cmd_posted,
    input  logic [3:0]       cmd_fbe,
    input  logic [2:0]       cmd_bar,
    input  logic [7:0]       cmd_fid,
    input  logic [DAT_W-1:0] cmd_wdata,
    output logic             res_done,
    output logic             res_ok,
    output logic [2:0]       res_err,
    output logic [7:0]       res_rsp,
    output logic [DAT_W-1:0] res_rdata,
    output logic             cfg_req,
    output logic             cfg_we,
    output logic             cfg_wide,
    output logic [CAD_W-1:0] cfg_addr,
    output logic [DAT_W-1:0] cfg_wdata,
    input  logic             cfg_ack,
    input  logic [DAT_W-1:0] cfg_rdata
);
    sbx_state_e       state, st_n;
    sbx_err_e         err_n, err_q;
    logic             end_n, accept, t_load, t_dec, t_last;
    logic             cap_sts, cap_rsp, cap_dat, issued_q;
    logic             go, fin;
    logic [DAT_W-1:0] fin_data;
    logic [CAD_W-1:0] a_addr;
    logic             a_we, a_wide;
    logic [DAT_W-1:0] a_wdata;

    logic [PID_W-1:0] pid_q;
    logic [OFS_W-1:0] ofs_q;
    logic [OP_W-1:0]  op_q;
    logic             posted_q;
    logic [3:0]       fbe_q;
    logic [2:0]       bar_q;
    logic [7:0]       fid_q;
    logic [DAT_W-1:0] wdata_q;
    logic [STS_W-1:0] sts_q;
    logic             done_q, ok_q;
    logic [7:0]       rsp_q;
    logic [DAT_W-1:0] rdata_q;

    logic [DAT_W-1:0] w_adr, w_ext, w_dat;
    logic [STS_W-1:0] w_sts, w_rte, w_go;

    sbx_field_pack u_pack (
        .pid(pid_q), .ofs(ofs_q), .op(op_q), .posted(posted_q), .fbe(fbe_q),
        .bar(bar_q), .fid(fid_q), .wdata(wdata_q), .sts_seen(sts_q),
        .adr_word(w_adr), .ext_word(w_ext), .sts_cfg(w_sts),
        .rte_word(w_rte), .dat_word(w_dat), .sts_go(w_go)
    );

    sbx_poll_timer #(.LIMIT(POLL_LIMIT)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(t_load), .dec(t_dec), .last(t_last)
    );

    sbx_cfg_port u_port (
        .clk(clk), .rst_n(rst_n), .go(go), .go_addr(a_addr), .go_we(a_we),
        .go_wide(a_wide), .go_wdata(a_wdata), .fin(fin), .fin_data(fin_data),
        .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_wide(cfg_wide),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_ack(cfg_ack),
        .cfg_rdata(cfg_rdata)
    );

    // Select the register access that belongs to the current step.
    always_comb begin
        a_addr  = RA_STAT;
        a_we    = 1'b0;
        a_wide  = 1'b0;
        a_wdata = '0;
        unique case (state)
            S_IDENT: a_addr = RA_IDENT;
            S_WADR:  begin a_addr = RA_ADDR;  a_we = 1'b1; a_wide = 1'b1; a_wdata = w_adr; end
            S_WEXT:  begin a_addr = RA_EXTA;  a_we = 1'b1; a_wide = 1'b1; a_wdata = w_ext; end
            S_WST:   begin a_we = 1'b1; a_wdata = {16'h0000, w_sts}; end
            S_WRTE:  begin a_addr = RA_ROUTE; a_we = 1'b1; a_wdata = {16'h0000, w_rte}; end
            S_WDAT:  begin a_addr = RA_DATA;  a_we = 1'b1; a_wide = 1'b1; a_wdata = w_dat; end
            S_WGO:   begin a_we = 1'b1; a_wdata = {16'h0000, w_go}; end
            S_RDAT:  begin a_addr = RA_DATA;  a_wide = 1'b1; end
            default: ;
        endcase
    end

    assign go        = (state != S_IDLE) && !issued_q;
    assign cmd_ready = (state == S_IDLE);

    // Next step, completion and capture decisions.
    always_comb begin
        st_n    = state;
        end_n   = 1'b0;
        err_n   = SBX_OK;
        accept  = 1'b0;
        t_load  = 1'b0;
        t_dec   = 1'b0;
        cap_sts = 1'b0;
        cap_rsp = 1'b0;
        cap_dat = 1'b0;
        unique case (state)
            S_IDLE: if (cmd_valid) begin
                accept = 1'b1;
                if (!sbx_op_legal(cmd_op)) begin end_n = 1'b1; err_n = SBX_BAD_OP; end
                else st_n = S_IDENT;
            end
            S_IDENT: if (fin) begin
                if (fin_data[15:0] == ID_ABSENT) begin end_n = 1'b1; err_n = SBX_HIDDEN; end
                else begin st_n = S_POLA; t_load = 1'b1; end
            end
            S_POLA: if (fin) begin
                if (!fin_data[0])  st_n = S_WADR;
                else if (t_last) begin end_n = 1'b1; err_n = SBX_TIMEOUT; end
                else               t_dec = 1'b1;
            end
            S_WADR: if (fin) st_n = S_WEXT;
            S_WEXT: if (fin) st_n = S_RST;
            S_RST:  if (fin) begin cap_sts = 1'b1; st_n = S_WST; end
            S_WST:  if (fin) st_n = S_WRTE;
            S_WRTE: if (fin) st_n = S_WDAT;
            S_WDAT: if (fin) st_n = S_RST2;
            S_RST2: if (fin) begin cap_sts = 1'b1; st_n = S_WGO; end
            S_WGO:  if (fin) begin st_n = S_POLB; t_load = 1'b1; end
            S_POLB: if (fin) begin
                if (!fin_data[0]) begin
                    cap_rsp = 1'b1;
                    if (fin_data[2:1] != 2'b00)  begin end_n = 1'b1; err_n = SBX_NACK; end
                    else if (sbx_op_reads(op_q)) st_n = S_RDAT;
                    else                         end_n = 1'b1;
                end else if (t_last) begin end_n = 1'b1; err_n = SBX_TIMEOUT; end
                else t_dec = 1'b1;
            end
            S_RDAT: if (fin) begin cap_dat = 1'b1; end_n = 1'b1; end
            default: st_n = S_IDLE;
        endcase
        if (end_n) st_n = S_IDLE;
    end

    // State, access bookkeeping and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            issued_q <= 1'b0;
            done_q   <= 1'b0;
            ok_q     <= 1'b0;
            err_q    <= SBX_OK;
            rsp_q    <= 8'hFF;
            rdata_q  <= '0;
            sts_q    <= '0;
            pid_q    <= '0;
            ofs_q    <= '0;
            op_q     <= '0;
            posted_q <= 1'b0;
            fbe_q    <= '0;
            bar_q    <= '0;
            fid_q    <= '0;
            wdata_q  <= '0;
        end else begin
            state  <= st_n;
            done_q <= end_n;
            if (fin)     issued_q <= 1'b0;
            else if (go) issued_q <= 1'b1;
            if (end_n) begin
                ok_q  <= (err_n == SBX_OK);
                err_q <= err_n;
            end
            if (accept) begin
                pid_q    <= cmd_pid;
                ofs_q    <= cmd_ofs;
                op_q     <= cmd_op;
                posted_q <= cmd_posted;
                fbe_q    <= cmd_fbe;
                bar_q    <= cmd_bar;
                fid_q    <= cmd_fid;
                wdata_q  <= cmd_wdata;
                rsp_q    <= 8'hFF;
                rdata_q  <= '0;
            end
            if (cap_sts) sts_q   <= fin_data[STS_W-1:0];
            if (cap_rsp) rsp_q   <= {6'b0, fin_data[2:1]};
            if (cap_dat) rdata_q <= fin_data;
        end
    end

    assign res_done  = done_q;
    assign res_ok    = ok_q;
    assign res_err   = err_q;
    assign res_rsp   = rsp_q;
    assign res_rdata = rdata_q;

    a_r1_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> !cmd_ready);
    a_r1_ok_matches_err: assert property (@(posedge clk) disable iff (!rst_n)
        res_done |-> (res_ok == (res_err == SBX_OK)));
    a_r2_bad_op_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && !sbx_op_legal(cmd_op))
            |=> (res_done && res_err == SBX_BAD_OP && !cfg_req));
    a_r10_preset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (res_done && !res_ok && res_err != SBX_NACK) |-> (res_rsp == 8'hFF));
    a_r10_nack_code: assert property (@(posedge clk) disable iff (!rst_n)
        (res_done && res_err == SBX_NACK) |-> (res_rsp inside {8'd1, 8'd2, 8'd3}));
    a_r11_rdata_only_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (res_done && !(res_ok && sbx_op_reads(op_q))) |-> (res_rdata == '0));

endmodule

// File: tb/sbx_seq_bench.sv
`timescale 1ns/1ps
// sbx_seq_bench: scoreboard bench. A planning task pushes the expected
// configuration accesses and the expected result; a mailbox model pops and
// compares each access, a result monitor pops and compares each done pulse.
module sbx_seq_bench;
    localparam int LIM = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [7:0]  cmd_pid = '0;
    logic [31:0] cmd_ofs = '0;
    logic [7:0]  cmd_op = '0;
    logic        cmd_posted = 1'b0;
    logic [3:0]  cmd_fbe = '0;
    logic [2:0]  cmd_bar = '0;
    logic [7:0]  cmd_fid = '0;
    logic [31:0] cmd_wdata = '0;
    logic        res_done, res_ok;
    logic [2:0]  res_err;
    logic [7:0]  res_rsp;
    logic [31:0] res_rdata;
    logic        cfg_req, cfg_we, cfg_wide;
    logic [7:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic        cfg_ack = 1'b0;
    logic [31:0] cfg_rdata = '0;

    sbx_seq #(.POLL_LIMIT(LIM)) u_sbx_seq (.*);

    always #2.5 clk = ~clk;

    typedef struct { logic [7:0] addr; logic we; logic wide; logic [31:0] wdata; string tag; } acc_t;
    typedef struct { logic ok; logic [2:0] err; logic [7:0] rsp; logic [31:0] rdata; string tag; } res_t;
    acc_t exp_acc[$];
    res_t exp_res[$];

    int checks = 0;
    int errors = 0;

    // Mailbox model configuration, set per test.
    logic [15:0] m_ident, m_stat;
    logic [31:0] m_rdval;
    int          m_busy, m_post_busy, m_lat;
    logic [1:0]  m_resp;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic push_acc(input logic [7:0] a, input logic we, input logic wide, input logic [31:0] d, input string tag);
        acc_t x;
        x.addr = a; x.we = we; x.wide = wide; x.wdata = d; x.tag = tag;
        exp_acc.push_back(x);
    endtask

    task automatic push_res(input logic ok, input logic [2:0] err, input logic [7:0] rsp, input logic [31:0] rd, input string tag);
        res_t r;
        r.ok = ok; r.err = err; r.rsp = rsp; r.rdata = rd; r.tag = tag;
        exp_res.push_back(r);
    endtask

    // Derive the expected access list and result from the requirements.
    task automatic plan(input logic [7:0] op, input logic posted, input logic [7:0] pid, input logic [31:0] ofs,
                        input logic [3:0] fbe, input logic [2:0] bar, input logic [7:0] fid, input logic [31:0] wd);
        logic [15:0] r1, w1, r2;
        bit legal, wr, rd;
        legal = op inside {8'd0, 8'd1, 8'd4, 8'd5, 8'd6, 8'd7, 8'd13};
        wr = op inside {8'd1, 8'd5, 8'd7};
        rd = op inside {8'd0, 8'd4, 8'd6};
        if (!legal) begin push_res(0, 3'd1, 8'hFF, 0, "R2"); return; end
        push_acc(8'h00, 0, 0, 0, "R3");
        if (m_ident == 16'hFFFF) begin push_res(0, 3'd2, 8'hFF, 0, "R3"); return; end
        if (m_busy + 1 > LIM) begin
            for (int i = 0; i < LIM; i++) push_acc(8'hD8, 0, 0, 0, "R4");
            push_res(0, 3'd3, 8'hFF, 0, "R4");
            return;
        end
        for (int i = 0; i <= m_busy; i++) push_acc(8'hD8, 0, 0, 0, "R4");
        push_acc(8'hD0, 1, 1, {pid, 8'h00, ofs[15:0]}, "R5");
        push_acc(8'hDC, 1, 1, {16'h0, ofs[31:16]}, "R5");
        push_acc(8'hD8, 0, 0, 0, "R6");
        r1 = {m_stat[15:1], 1'b0};
        w1 = (r1 & 16'h007F) | {op, 8'h00} | {8'h00, posted, 7'h00};
        push_acc(8'hD8, 1, 0, {16'h0, w1}, "R6");
        push_acc(8'hDA, 1, 0, {16'h0, fbe, 1'b0, bar, fid}, "R7");
        push_acc(8'hD4, 1, 1, wr ? wd : 32'h0, "R8");
        push_acc(8'hD8, 0, 0, 0, "R9");
        r2 = {w1[15:1], 1'b0};
        push_acc(8'hD8, 1, 0, {16'h0, r2 | 16'h1}, "R9");
        if (m_post_busy + 1 > LIM) begin
            for (int i = 0; i < LIM; i++) push_acc(8'hD8, 0, 0, 0, "R9");
            push_res(0, 3'd3, 8'hFF, 0, "R9");
            return;
        end
        for (int i = 0; i <= m_post_busy; i++) push_acc(8'hD8, 0, 0, 0, "R9");
        if (m_resp != 2'b00) begin push_res(0, 3'd4, {6'b0, m_resp}, 0, "R10"); return; end
        if (rd) begin
            push_acc(8'hD4, 0, 1, 0, "R11");
            push_res(1, 3'd0, 8'h00, m_rdval, "R11");
        end else push_res(1, 3'd0, 8'h00, 0, "R8");
    endtask

    // Mailbox model and access monitor: compares each access as it is acked.
    initial begin
        int wait_left;
        bit open;
        logic [7:0]  s_addr;
        logic [31:0] s_wdata;
        acc_t e;
        wait_left = 0;
        open = 0;
        forever begin
            @(negedge clk);
            if (cfg_ack) begin
                cfg_ack = 1'b0;
            end else if (cfg_req) begin
                if (!open) begin open = 1; wait_left = m_lat; s_addr = cfg_addr; s_wdata = cfg_wdata; end
                if (wait_left > 0) wait_left--;
                else begin
                    open = 0;
                    chk("R12", "held address", {24'h0, cfg_addr}, {24'h0, s_addr});
                    chk("R12", "held data", cfg_wdata, s_wdata);
                    if (exp_acc.size() == 0) chk("R1", "unexpected access addr", {24'h0, cfg_addr}, 32'hFFFF_FFFF);
                    else begin
                        e = exp_acc.pop_front();
                        chk(e.tag, "access addr", {24'h0, cfg_addr}, {24'h0, e.addr});
                        chk(e.tag, "access dir/width", {30'h0, cfg_we, cfg_wide}, {30'h0, e.we, e.wide});
                        if (e.we) chk(e.tag, "access wdata", cfg_wdata, e.wdata);
                    end
                    cfg_rdata = 32'h0;
                    if (!cfg_we) begin
                        case (cfg_addr)
                            8'h00: cfg_rdata = {16'h0, m_ident};
                            8'hD4: cfg_rdata = m_rdval;
                            8'hD8: begin
                                cfg_rdata = {16'h0, m_stat[15:1], m_busy != 0};
                                if (m_busy != 0) m_busy--;
                            end
                            default: ;
                        endcase
                    end else if (cfg_addr == 8'hD8) begin
                        if (cfg_wdata[0]) begin
                            m_stat = {cfg_wdata[15:3], m_resp, 1'b0};
                            m_busy = m_post_busy;
                        end else m_stat = cfg_wdata[15:0];
                    end
                    cfg_ack = 1'b1;
                end
            end
        end
    end

    // Result monitor: compares each done pulse against the queue.
    initial begin
        res_t r;
        forever begin
            @(negedge clk);
            if (res_done === 1'b1) begin
                if (exp_res.size() == 0) chk("R1", "unexpected done", 1, 0);
                else begin
                    r = exp_res.pop_front();
                    chk(r.tag, "ok", {31'h0, res_ok}, {31'h0, r.ok});
                    chk(r.tag, "err", {29'h0, res_err}, {29'h0, r.err});
                    chk("R10", "rsp", {24'h0, res_rsp}, {24'h0, r.rsp});
                    chk("R11", "rdata", res_rdata, r.rdata);
                    chk(r.tag, "accesses left", exp_acc.size(), 0);
                end
                @(negedge clk);
                chk("R1", "done single cycle", {31'h0, res_done}, 0);
            end
        end
    end

    // Run one command through the design and wait for its result.
    task automatic run(input logic [7:0] op, input logic posted, input logic [7:0] pid, input logic [31:0] ofs,
                       input logic [3:0] fbe, input logic [2:0] bar, input logic [7:0] fid, input logic [31:0] wd);
        plan(op, posted, pid, ofs, fbe, bar, fid, wd);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_posted = posted; cmd_pid = pid; cmd_ofs = ofs;
        cmd_fbe = fbe; cmd_bar = bar; cmd_fid = fid; cmd_wdata = wd;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (op inside {8'd0, 8'd1, 8'd4, 8'd5, 8'd6, 8'd7, 8'd13})
            chk("R1", "ready while busy", {31'h0, cmd_ready}, 0);
        while (exp_res.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic cfg_model(input logic [15:0] ident, input logic [15:0] stat, input int pre, input int post,
                             input logic [1:0] resp, input logic [31:0] rdv, input int lat);
        m_ident = ident; m_stat = stat; m_busy = pre; m_post_busy = post;
        m_resp = resp; m_rdval = rdv; m_lat = lat;
    endtask

    initial begin
        cfg_model(16'h8086, 16'h0000, 0, 0, 2'b00, 32'h0, 0);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "reset ready", {31'h0, cmd_ready}, 1);
        chk("R1", "reset done", {31'h0, res_done}, 0);
        chk("R12", "reset req", {31'h0, cfg_req}, 0);
        chk("R10", "reset rsp", {24'h0, res_rsp}, 32'hFF);

        cfg_model(16'h1234, 16'h0000, 0, 0, 2'b00, 32'h0, 0);
        run(8'd2, 1'b0, 8'hC1, 32'h10, 4'hF, 3'd0, 8'h00, 32'h0);           // R2 illegal
        cfg_model(16'hFFFF, 16'h0000, 0, 0, 2'b00, 32'h0, 1);
        run(8'd6, 1'b0, 8'hC1, 32'h10, 4'hF, 3'd0, 8'h00, 32'h0);           // R3 hidden
        cfg_model(16'h1234, 16'hAB7A, 2, 1, 2'b00, 32'h0, 2);
        run(8'd7, 1'b1, 8'h6E, 32'h0000_4C20, 4'hF, 3'd0, 8'h00, 32'h5A5A_0F0F); // R5-R9 write
        cfg_model(16'h1234, 16'h0000, 1, 3, 2'b00, 32'hCAFE_F00D, 0);
        run(8'd6, 1'b0, 8'h3B, 32'h0000_0104, 4'h3, 3'd2, 8'hA5, 32'h0);    // R11 read
        cfg_model(16'h1234, 16'h0000, 0, 0, 2'b10, 32'hDEAD_BEEF, 1);
        run(8'd0, 1'b0, 8'h11, 32'h0002_0008, 4'h1, 3'd7, 8'h01, 32'h0);    // R10 negative response
        cfg_model(16'h1234, 16'h0000, LIM, 0, 2'b00, 32'h0, 0);
        run(8'd1, 1'b0, 8'h22, 32'h40, 4'hF, 3'd0, 8'h00, 32'h1);           // R4 timeout
        cfg_model(16'h1234, 16'h0000, LIM - 1, LIM - 1, 2'b00, 32'h0, 0);
        run(8'd5, 1'b1, 8'h22, 32'hABCD_1234, 4'hC, 3'd5, 8'h7F, 32'h0BAD_CAFE); // R4 R9 boundary
        cfg_model(16'h1234, 16'h0006, 0, LIM, 2'b00, 32'h0, 1);
        run(8'd4, 1'b0, 8'h33, 32'h8, 4'hF, 3'd1, 8'h10, 32'h0);            // R9 completion timeout
        cfg_model(16'h1234, 16'hFF00, 0, 0, 2'b00, 32'h0, 0);
        run(8'd13, 1'b0, 8'h44, 32'hFFFF_FFFF, 4'h0, 3'd0, 8'hFF, 32'h1357_9BDF); // R8 dummy data
        cfg_model(16'h1234, 16'h0000, 0, 0, 2'b00, 32'h0, 0);
        run(8'd255, 1'b1, 8'h44, 32'h0, 4'h0, 3'd0, 8'h00, 32'h0);          // R2 illegal high

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R1 watchdog actual %0d cycles expected fewer", 100000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule